// File: doc/BRIEF.md
# High-Register Compare, Move and Branch-Exchange Unit

This execution unit serves the 16-bit compressed instruction encoding for the group of operations that can name any of the sixteen general registers. Two high-bank bits in the instruction extend the usual 3-bit register fields to 4-bit indices. The unit decodes the instruction and drives the source and destination indices at once, so a register file can return both operand values in the same cycle. It then carries out one of three operations: compare, register move, or branch with exchange of instruction-set state.

The caller asserts `instr_valid` with the instruction, the two operand values read from the indices and the current condition flags. One clock later the unit presents its registered results as single-cycle strobes. These are a register write-back, a flag update, or a program-counter load together with a pipeline flush and a new state bit. An operation code of 00 raises an illegal-instruction strobe instead. The register file, the program counter and the state register all sit outside the block.

Top module: `hireg_bx_unit`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high and `instr[15:10]` equals 6'b010001. Any other cycle produces no strobe, keeps `done` low and leaves `flags_out` unchanged.
- R2: `src_idx` is `{instr[6], instr[5:3]}` and `dst_idx` is `{instr[7], instr[2:0]}`. Both follow `instr` combinationally.
- R3: Operation code `instr[9:8]` = 01 computes destination minus source. On the next cycle it pulses `flags_we`, writes no register, and sets `flags_out` to {N,Z,C,V} in bits 3..0. N is bit 31 of the difference, Z is set for a zero difference, C is set when no borrow occurs (dst >= src unsigned), and V is set on signed overflow.
- R4: Operation code 10 pulses `wb_en` with `wb_idx` equal to the destination index and `wb_data` equal to the source value. `flags_we` stays low and `flags_out` equals the sampled `flags_in`.
- R5: Operation code 11 pulses `pc_load` with `pc_next` equal to the source value with bit 0 forced to zero.
- R6: Operation code 11 pulses `state_load` with `state_next` equal to bit 0 of the source value.
- R7: A branch with exchange pulses `flush` in the same cycle as `pc_load`, and `flush` never rises otherwise.
- R8: Operation code 00 pulses `illegal` and raises no write-back, flag, PC or state strobe.
- R9: Results appear exactly one cycle after the accepting edge. `done` pulses with them, and each strobe lasts one cycle unless the next cycle also accepts an instruction of the same kind.
- R10: During and right after reset every strobe and `done` is low, and `wb_data`, `pc_next`, `flags_out` and `state_next` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Compressed instruction word |
| src_val | input | 32 | Value read at `src_idx` |
| dst_val | input | 32 | Value read at `dst_idx` |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| src_idx | output | 4 | Source register index |
| dst_idx | output | 4 | Destination register index |
| done | output | 1 | Result valid pulse |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 4 | Register write index |
| wb_data | output | 32 | Register write data |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 4 | Flags after the operation {N,Z,C,V} |
| pc_load | output | 1 | Program-counter load strobe |
| pc_next | output | 32 | New program counter |
| flush | output | 1 | Pipeline flush pulse |
| state_load | output | 1 | State bit update strobe |
| state_next | output | 1 | New instruction-set state bit |
| illegal | output | 1 | Illegal operation pulse |

## Verification
The assertions assume that `src_val` and `dst_val` are the contents of the registers named by the unit's own index outputs in the same cycle as `instr_valid`. They also assume that `flags_in` is the live flag state at that edge. The bench keeps this true by holding a sixteen-entry register model and a flag model, driving the operand values from the model at the indices it decodes itself, and applying every write-back and flag update it expects before the next instruction. Random words mix in-format instructions of every operation code with out-of-format words, so that the ignored path is also exercised under these same assumptions.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
  localparam logic [5:0] HRX_TAG = 6'b010001;

  typedef enum logic [1:0] {
    OP_BAD = 2'b00,
    OP_CMP = 2'b01,
    OP_MOV = 2'b10,
    OP_BX  = 2'b11
  } hrx_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } hrx_flags_t;
endpackage

// File: rtl/hrx_decode.sv
module hrx_decode
  import hrx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [15:0]      instr,
  output logic             fmt_hit,
  output hrx_op_e          op,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx
);
  localparam int LO_W = IDX_W - 1;

  assign fmt_hit = (instr[15:10] == HRX_TAG);
  assign op      = hrx_op_e'(instr[9:8]);
  // high-bank bit joins the 3-bit field
  assign src_idx = {instr[6], instr[3 +: LO_W]};
  assign dst_idx = {instr[7], instr[0 +: LO_W]};
endmodule

// File: rtl/hrx_alu.sv
module hrx_alu
  import hrx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] dst_val,
  output hrx_flags_t   cmp_flags,
  output logic [W-1:0] pc_target,
  output logic         state_bit
);
  function automatic hrx_flags_t sub_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    hrx_flags_t f;
    logic [W:0] full;
    full = {1'b0, a} - {1'b0, b};
    f.n = full[W-1];
    f.z = (full[W-1:0] == '0);
    f.c = ~full[W];
    f.v = (a[W-1] ^ b[W-1]) & (a[W-1] ^ full[W-1]);
    return f;
  endfunction

  function automatic logic [W-1:0] clear_lsb(input logic [W-1:0] a);
    return {a[W-1:1], 1'b0};
  endfunction

  assign cmp_flags = sub_flags(dst_val, src_val);
  assign pc_target = clear_lsb(src_val);
  assign state_bit = src_val[0];
endmodule

// File: rtl/hrx_outreg.sv
module hrx_outreg
  import hrx_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  hrx_op_e          op,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [W-1:0]     src_val,
  input  hrx_flags_t       cmp_flags,
  input  hrx_flags_t       flags_in,
  input  logic [W-1:0]     pc_target,
  input  logic             state_bit,
  output logic             done,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic [W-1:0]     wb_data,
  output logic             flags_we,
  output hrx_flags_t       flags_out,
  output logic             pc_load,
  output logic [W-1:0]     pc_next,
  output logic             flush,
  output logic             state_load,
  output logic             state_next,
  output logic             illegal
);
  logic is_cmp, is_mov, is_bx, is_bad;
  assign is_cmp = take && (op == OP_CMP);
  assign is_mov = take && (op == OP_MOV);
  assign is_bx  = take && (op == OP_BX);
  assign is_bad = take && (op == OP_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      wb_en      <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
      flags_we   <= 1'b0;
      flags_out  <= '0;
      pc_load    <= 1'b0;
      pc_next    <= '0;
      flush      <= 1'b0;
      state_load <= 1'b0;
      state_next <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      done       <= take;
      wb_en      <= is_mov;
      flags_we   <= is_cmp;
      pc_load    <= is_bx;
      flush      <= is_bx;
      state_load <= is_bx;
      illegal    <= is_bad;
      if (take) begin
        wb_idx    <= dst_idx;
        flags_out <= is_cmp ? cmp_flags : flags_in;
      end
      if (is_mov) wb_data <= src_val;
      if (is_bx) begin
        pc_next    <= pc_target;
        state_next <= state_bit;
      end
    end
  end
endmodule

// File: rtl/hireg_bx_unit.sv
module hireg_bx_unit
  import hrx_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [15:0]      instr,
  input  logic [W-1:0]     src_val,
  input  logic [W-1:0]     dst_val,
  input  logic [3:0]       flags_in,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx,
  output logic             done,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic [W-1:0]     wb_data,
  output logic             flags_we,
  output logic [3:0]       flags_out,
  output logic             pc_load,
  output logic [W-1:0]     pc_next,
  output logic             flush,
  output logic             state_load,
  output logic             state_next,
  output logic             illegal
);
  // named internal events
  logic       fmt_hit;
  logic       take;
  hrx_op_e    op;
  hrx_flags_t cmp_flags;
  hrx_flags_t flags_q;
  logic [W-1:0] pc_target;
  logic       state_bit;

  hrx_decode #(.IDX_W(IDX_W)) u_dec (
    .instr   (instr),
    .fmt_hit (fmt_hit),
    .op      (op),
    .src_idx (src_idx),
    .dst_idx (dst_idx)
  );

  assign take = instr_valid && fmt_hit;

  hrx_alu #(.W(W)) u_alu (
    .src_val   (src_val),
    .dst_val   (dst_val),
    .cmp_flags (cmp_flags),
    .pc_target (pc_target),
    .state_bit (state_bit)
  );

  hrx_outreg #(.W(W), .IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .op         (op),
    .dst_idx    (dst_idx),
    .src_val    (src_val),
    .cmp_flags  (cmp_flags),
    .flags_in   (hrx_flags_t'(flags_in)),
    .pc_target  (pc_target),
    .state_bit  (state_bit),
    .done       (done),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .flags_we   (flags_we),
    .flags_out  (flags_q),
    .pc_load    (pc_load),
    .pc_next    (pc_next),
    .flush      (flush),
    .state_load (state_load),
    .state_next (state_next),
    .illegal    (illegal)
  );

  assign flags_out = flags_q;
endmodule

// File: rtl/hireg_bx_unit_chk.sv
module hireg_bx_unit_chk #(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [15:0]      instr,
  input logic [W-1:0]     src_val,
  input logic [W-1:0]     dst_val,
  input logic [3:0]       flags_in,
  input logic             done,
  input logic             wb_en,
  input logic [IDX_W-1:0] wb_idx,
  input logic [W-1:0]     wb_data,
  input logic             flags_we,
  input logic [3:0]       flags_out,
  input logic             pc_load,
  input logic [W-1:0]     pc_next,
  input logic             flush,
  input logic             state_load,
  input logic             state_next,
  input logic             illegal
);
  logic hit;
  assign hit = instr_valid && (instr[15:10] == 6'b010001);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, flags_we, pc_load, illegal}));

  // R1
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !done && !wb_en && !flags_we && !pc_load && !illegal && $stable(flags_out));

  // R3
  cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && instr[9:8] == 2'b01 |=> flags_we && !wb_en
      && flags_out[2] == ($past(dst_val) == $past(src_val))
      && flags_out[1] == ($past(dst_val) >= $past(src_val)));

  // R4
  mov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && instr[9:8] == 2'b10 |=> wb_en && !flags_we
      && wb_data == $past(src_val)
      && wb_idx == {$past(instr[7]), $past(instr[2:0])}
      && flags_out == $past(flags_in));

  // R5
  bx_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && instr[9:8] == 2'b11 |=> pc_load && !pc_next[0]
      && pc_next[W-1:1] == $past(src_val[W-1:1]));

  // R6
  bx_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && instr[9:8] == 2'b11 |=> state_load && state_next == $past(src_val[0]));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> pc_load);

  // R8
  bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && instr[9:8] == 2'b00 |=> illegal && !state_load && !flush);

  // R9
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> done);
endmodule

bind hireg_bx_unit hireg_bx_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/hireg_bx_unit_tb.sv
module hireg_bx_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] src_val = '0;
  logic [31:0] dst_val = '0;
  logic [3:0]  flags_in = '0;
  logic [3:0]  src_idx, dst_idx, wb_idx;
  logic        done, wb_en, flags_we, pc_load, flush, state_load, state_next, illegal;
  logic [31:0] wb_data, pc_next;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] regs [16];
  logic [3:0]  fl;

  always #2.5 clk = ~clk;

  hireg_bx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .src_val(src_val), .dst_val(dst_val), .flags_in(flags_in),
    .src_idx(src_idx), .dst_idx(dst_idx), .done(done), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .flags_we(flags_we),
    .flags_out(flags_out), .pc_load(pc_load), .pc_next(pc_next),
    .flush(flush), .state_load(state_load), .state_next(state_next),
    .illegal(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
    longint sd;
    logic [31:0] r;
    logic n, z, c, v;
    r  = a - b;
    sd = longint'($signed(a)) - longint'($signed(b));
    n  = r[31];
    z  = (a == b);
    c  = (a >= b);
    v  = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    return {n, z, c, v};
  endfunction

  task automatic run(input logic vld, input logic [15:0] w);
    logic hit;
    logic [1:0] op;
    logic [3:0] s, d;
    logic [31:0] sv, dv;
    logic [3:0] fl_before;
    hit = vld && (w[15:10] == 6'b010001);
    op  = w[9:8];
    s   = {w[6], w[5:3]};
    d   = {w[7], w[2:0]};
    sv  = regs[s];
    dv  = regs[d];
    fl_before = fl;
    @(negedge clk);
    instr_valid = vld; instr = w; src_val = sv; dst_val = dv; flags_in = fl;
    #1;
    check("R2 src_idx", 32'(src_idx), 32'(s));
    check("R2 dst_idx", 32'(dst_idx), 32'(d));
    @(posedge clk); #1;
    check("R9 done", 32'(done), 32'(hit));
    check("R8 illegal", 32'(illegal), 32'(hit && op == 2'b00));
    check("R3 flags_we", 32'(flags_we), 32'(hit && op == 2'b01));
    check("R4 wb_en", 32'(wb_en), 32'(hit && op == 2'b10));
    check("R5 pc_load", 32'(pc_load), 32'(hit && op == 2'b11));
    check("R6 state_load", 32'(state_load), 32'(hit && op == 2'b11));
    check("R7 flush", 32'(flush), 32'(hit && op == 2'b11));
    if (!hit) check("R1 flags held", 32'(flags_out), 32'(fl_before));
    else if (op == 2'b01) begin
      fl = exp_flags(dv, sv);
      check("R3 flags", 32'(flags_out), 32'(fl));
    end else begin
      check("R4 flags kept", 32'(flags_out), 32'(fl_before));
      if (op == 2'b10) begin
        check("R4 wb_idx", 32'(wb_idx), 32'(d));
        check("R4 wb_data", wb_data, sv);
        regs[d] = sv;
      end else if (op == 2'b11) begin
        check("R5 pc_next", pc_next, sv & 32'hFFFF_FFFE);
        check("R6 state_next", 32'(state_next), 32'(sv[0]));
      end
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] op, input logic [3:0] d, input logic [3:0] s);
    return {6'b010001, op, d[3], s[3], s[2:0], d[2:0]};
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    fl = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 done", 32'(done), 0);
    check("R10 strobes", 32'({wb_en, flags_we, pc_load, flush, state_load, illegal}), 0);
    check("R10 data", wb_data | pc_next | 32'(flags_out) | 32'(state_next), 0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    regs[3] = 32'h1234_5678; regs[12] = 32'h1234_5678;
    run(1'b1, mk(2'b01, 4'd12, 4'd3));            // R3 equal: Z,C
    regs[1] = 32'd0; regs[9] = 32'd1;
    run(1'b1, mk(2'b01, 4'd1, 4'd9));             // R3 borrow: N, no C
    regs[2] = 32'h8000_0000; regs[10] = 32'd1;
    run(1'b1, mk(2'b01, 4'd2, 4'd10));            // R3 overflow: V
    regs[15] = 32'h0800_0101;
    run(1'b1, mk(2'b11, 4'd0, 4'd15));            // R5/R6 odd target
    regs[14] = 32'h0300_0004;
    run(1'b1, mk(2'b11, 4'd0, 4'd14));            // R5/R6 even target
    run(1'b1, mk(2'b10, 4'd15, 4'd8));            // R4 high to high
    run(1'b1, mk(2'b00, 4'd5, 4'd6));             // R8 illegal
    run(1'b1, 16'h4000);                          // R1 out of format
    run(1'b0, mk(2'b10, 4'd4, 4'd11));            // R1 no strobe
    run(1'b1, mk(2'b11, 4'd1, 4'd2));             // R9 back-to-back
    run(1'b1, mk(2'b11, 4'd3, 4'd4));

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 8) != 0) w[15:10] = 6'b010001;
      else if (w[15:10] == 6'b010001) w[15] = 1'b1;
      if (($urandom % 6) == 0) regs[{w[6], w[5:3]}] = regs[{w[7], w[2:0]}];
      run(($urandom % 10) != 0, w);
    end

    @(negedge clk); instr_valid = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule